// File: doc/BRIEF.md
# Partitioned Add Subtract Compare Unit

This block is a single-stage SIMD integer unit for a 64-bit data path. It treats each operand as a set of independent lanes and adds or subtracts them lane by lane with wraparound. The lanes can be four 16-bit lanes or two 32-bit lanes over the full word. They can also be two 16-bit lanes or one 32-bit lane over the low 32 bits only. The same datapath also compares lanes, in 16-bit or 32-bit lane width, and packs the per-lane outcome into a small bit mask at the bottom of the result. A third mode widens four bytes into four 16-bit fixed-point lanes.

An operation is presented with `in_valid_i` together with an operation code, a lane-size select and two 64-bit operands. The result is registered. It appears with `out_valid_o` on the next clock edge and stays unchanged until another operation is accepted.

Top module: `lane_alu`

## Requirements
- R1: The result register updates only in a cycle where `in_valid_i` is high, and the new value is visible after that edge. `out_valid_o` equals `in_valid_i` delayed by one clock. While `in_valid_i` is low, `res_o` holds its value.
- R2: Operation code 4'h1 adds `a_i` and `b_i` lane by lane. Each lane wraps modulo its width, and no carry passes from one lane into the next.
- R3: Operation code 4'h2 subtracts lane by lane, computing the `b_i` lane minus the `a_i` lane. Each lane wraps, and no borrow passes between lanes.
- R4: For add and subtract, `size_i` selects the lane layout: 2'b00 gives four 16-bit lanes, 2'b01 two 32-bit lanes, 2'b10 two 16-bit lanes over bits 31:0, and 2'b11 one 32-bit lane over bits 31:0. In the two 32-bit-data layouts, `res_o[63:32]` is zero.
- R5: Compare codes are 4'h4 for greater-than, 4'h5 for equal, 4'h6 for less-or-equal and 4'h7 for not-equal. Each tests the `a_i` lane against the `b_i` lane, with both treated as unsigned.
- R6: A compare with `size_i[0]`=0 uses four 16-bit lanes. Bit r of `res_o` is set when lane r (bits 16r+15:16r) meets the condition, and `res_o[63:4]` is zero.
- R7: A compare with `size_i[0]`=1 uses two 32-bit lanes. Only bits 0 and 1 can be set, and `res_o[63:2]` is zero. For compares, `size_i[1]` has no effect.
- R8: Operation code 4'h8 expands bytes. For r from 0 to 3, lane r of the result is `{4'b0, a_i[8r+7:8r], 4'b0}`. `b_i` and `size_i` have no effect on this operation.
- R9: Every other operation code (4'h0, 4'h3 and 4'h9 to 4'hF) produces an all-zero result.
- R10: While `rst_ni` is low, `out_valid_o` is 0 and `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Lane layout select |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| out_valid_o | output | 1 | Result register was loaded on the last edge |
| res_o | output | 64 | Registered result |

## Verification
The assertions assume that `in_valid_i`, `op_i`, `size_i` and `a_i` are stable across a clock edge and hold known values after reset. They also assume that `in_valid_i` is low for the whole reset period. The bench meets these assumptions by driving every input on the falling edge and holding `in_valid_i` low until reset has been released. The random operation codes cover all sixteen values, so the legal, illegal and expand cases each occur often. Some operand pairs are made partly equal, so the equal and not-equal compares produce both outcomes.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned LANE_W = 16;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h1,
        OP_SUB  = 4'h2,
        OP_CGT  = 4'h4,
        OP_CEQ  = 4'h5,
        OP_CLE  = 4'h6,
        OP_CNE  = 4'h7,
        OP_EXP  = 4'h8
    } op_e;

    typedef enum logic [1:0] {
        CND_GT = 2'd0,
        CND_EQ = 2'd1,
        CND_LE = 2'd2,
        CND_NE = 2'd3
    } cond_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage_t;

endpackage

// File: rtl/lane_addsub.sv
module lane_addsub #(
    parameter int unsigned W  = 64,
    parameter int unsigned SW = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         wide_i,
    output logic [W-1:0] sum_o
);
    localparam int unsigned NS = W / SW;

    logic [NS-1:0] cin;
    logic [NS-1:0] cout;

    for (genvar k = 0; k < NS; k++) begin : g_slice
        logic [SW-1:0] a_op;
        logic [SW:0]   full;

        if (k % 2 == 1) begin : g_link
            assign cin[k] = wide_i ? cout[k-1] : sub_i;
        end else begin : g_base
            assign cin[k] = sub_i;
        end

        assign a_op     = sub_i ? ~a_i[k*SW +: SW] : a_i[k*SW +: SW];
        assign full     = {1'b0, b_i[k*SW +: SW]} + {1'b0, a_op} + {{SW{1'b0}}, cin[k]};
        assign cout[k]  = full[SW];
        assign sum_o[k*SW +: SW] = full[SW-1:0];
    end

endmodule

// File: rtl/lane_cmp.sv
module lane_cmp
    import lane_alu_pkg::*;
#(
    parameter int unsigned W  = 64,
    parameter int unsigned SW = 16
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            wide_i,
    input  cond_e           cond_i,
    output logic [W/SW-1:0] mask_o
);
    localparam int unsigned NN = W / SW;
    localparam int unsigned NW = W / (2 * SW);

    logic [NN-1:0] hit_n;
    logic [NW-1:0] hit_w;

    for (genvar k = 0; k < NN; k++) begin : g_narrow
        logic [SW-1:0] x;
        logic [SW-1:0] y;
        assign x = a_i[k*SW +: SW];
        assign y = b_i[k*SW +: SW];
        always_comb begin
            unique case (cond_i)
                CND_GT:  hit_n[k] = x >  y;
                CND_EQ:  hit_n[k] = x == y;
                CND_LE:  hit_n[k] = x <= y;
                default: hit_n[k] = x != y;
            endcase
        end
    end

    for (genvar j = 0; j < NW; j++) begin : g_wide
        logic [2*SW-1:0] x;
        logic [2*SW-1:0] y;
        assign x = a_i[j*2*SW +: 2*SW];
        assign y = b_i[j*2*SW +: 2*SW];
        always_comb begin
            unique case (cond_i)
                CND_GT:  hit_w[j] = x >  y;
                CND_EQ:  hit_w[j] = x == y;
                CND_LE:  hit_w[j] = x <= y;
                default: hit_w[j] = x != y;
            endcase
        end
    end

    assign mask_o = wide_i ? {{(NN-NW){1'b0}}, hit_w} : hit_n;

endmodule

// File: rtl/lane_expand.sv
module lane_expand #(
    parameter int unsigned W  = 64,
    parameter int unsigned SW = 16
) (
    input  logic [W/2-1:0] a_i,
    output logic [W-1:0]   exp_o
);
    localparam int unsigned NL  = W / SW;
    localparam int unsigned BW  = W / (2 * NL);
    localparam int unsigned PAD = (SW - BW) / 2;

    for (genvar r = 0; r < NL; r++) begin : g_lane
        assign exp_o[r*SW +: SW] = {{(SW-BW-PAD){1'b0}}, a_i[r*BW +: BW], {PAD{1'b0}}};
    end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
    import lane_alu_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] res_o
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned NL     = DATA_W / LANE_W;

    stage_t            st_d, st_q;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] expd;
    logic [NL-1:0]     mask;
    logic              is_sub;
    cond_e             cond;

    assign is_sub = (op_i == OP_SUB);

    always_comb begin
        unique case (op_i)
            OP_CGT:  cond = CND_GT;
            OP_CEQ:  cond = CND_EQ;
            OP_CLE:  cond = CND_LE;
            default: cond = CND_NE;
        endcase
    end

    lane_addsub #(.W(DATA_W), .SW(LANE_W)) i_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (is_sub),
        .wide_i (size_i[0]),
        .sum_o  (sum)
    );

    lane_cmp #(.W(DATA_W), .SW(LANE_W)) i_cmp (
        .a_i    (a_i),
        .b_i    (b_i),
        .wide_i (size_i[0]),
        .cond_i (cond),
        .mask_o (mask)
    );

    lane_expand #(.W(DATA_W), .SW(LANE_W)) i_expand (
        .a_i   (a_i[HALF_W-1:0]),
        .exp_o (expd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid_i;
        if (in_valid_i) begin
            unique case (op_i)
                OP_ADD, OP_SUB: begin
                    st_d.res = sum;
                    if (size_i[1]) begin
                        st_d.res[DATA_W-1:HALF_W] = '0;
                    end
                end
                OP_CGT, OP_CEQ, OP_CLE, OP_CNE: begin
                    st_d.res = {{(DATA_W-NL){1'b0}}, mask};
                end
                OP_EXP: begin
                    st_d.res = expd;
                end
                default: begin
                    st_d.res = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign res_o       = st_q.res;

endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        in_valid_i,
    input logic [3:0]  op_i,
    input logic [1:0]  size_i,
    input logic [63:0] a_i,
    input logic        out_valid_o,
    input logic [63:0] res_o
);

    always_comb begin
        if (!rst_ni) begin
            p_reset_clear_r10: assert (out_valid_o == 1'b0 && res_o == '0);
        end
    end

    p_valid_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o == $past(in_valid_i));

    p_hold_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(res_o));

    p_narrow_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (op_i == 4'h1 || op_i == 4'h2) && size_i[1])
        |=> res_o[63:32] == 32'h0);

    p_mask16_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_i >= 4'h4 && op_i <= 4'h7 && !size_i[0])
        |=> res_o[63:4] == 60'h0);

    p_mask32_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_i >= 4'h4 && op_i <= 4'h7 && size_i[0])
        |=> res_o[63:2] == 62'h0);

    p_expand_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_i == 4'h8)
        |=> res_o == {4'h0, $past(a_i[31:24]), 8'h0, $past(a_i[23:16]), 8'h0,
                      $past(a_i[15:8]), 8'h0, $past(a_i[7:0]), 4'h0});

    p_illegal_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (op_i == 4'h0 || op_i == 4'h3 || op_i >= 4'h9))
        |=> res_o == 64'h0);

endmodule

bind lane_alu lane_alu_chk i_lane_alu_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .size_i      (size_i),
    .a_i         (a_i),
    .out_valid_o (out_valid_o),
    .res_o       (res_o)
);

// File: tb/test_lane_alu.sv
module test_lane_alu;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        out_valid_o;
    logic [63:0] res_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    lane_alu i_lane_alu (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (in_valid_i),
        .op_i        (op_i),
        .size_i      (size_i),
        .a_i         (a_i),
        .b_i         (b_i),
        .out_valid_o (out_valid_o),
        .res_o       (res_o)
    );

    function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] sz,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        case (op)
            4'h1, 4'h2: begin
                if (!sz[0]) begin
                    for (int k = 0; k < 4; k++) begin
                        r[16*k +: 16] = (op == 4'h1) ? a[16*k +: 16] + b[16*k +: 16]
                                                     : b[16*k +: 16] - a[16*k +: 16];
                    end
                end else begin
                    for (int k = 0; k < 2; k++) begin
                        r[32*k +: 32] = (op == 4'h1) ? a[32*k +: 32] + b[32*k +: 32]
                                                     : b[32*k +: 32] - a[32*k +: 32];
                    end
                end
                if (sz[1]) r[63:32] = '0;
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                int w = sz[0] ? 32 : 16;
                int n = sz[0] ? 2 : 4;
                for (int k = 0; k < n; k++) begin
                    logic [31:0] x = (a >> (w*k)) & ((64'h1 << w) - 1);
                    logic [31:0] y = (b >> (w*k)) & ((64'h1 << w) - 1);
                    case (op)
                        4'h4:    r[k] = x >  y;
                        4'h5:    r[k] = x == y;
                        4'h6:    r[k] = x <= y;
                        default: r[k] = x != y;
                    endcase
                end
            end
            4'h8: begin
                for (int k = 0; k < 4; k++) r[16*k +: 16] = {8'h0, a[8*k +: 8]} << 4;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic [1:0] sz);
        case (op)
            4'h1:                   return sz[1] ? "R2/R4" : "R2";
            4'h2:                   return sz[1] ? "R3/R4" : "R3";
            4'h4, 4'h5, 4'h6, 4'h7: return sz[0] ? "R5/R7" : "R5/R6";
            4'h8:                   return "R8";
            default:                return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    logic [63:0] last_exp = '0;

    task automatic run_op(input logic [3:0] op, input logic [1:0] sz,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk_i);
        in_valid_i = 1'b1; op_i = op; size_i = sz; a_i = a; b_i = b;
        @(negedge clk_i);
        last_exp = model(op, sz, a, b);
        check("R1 out_valid", {63'h0, out_valid_o}, 64'h1);
        check(tag_of(op, sz), res_o, last_exp);
    endtask

    task automatic idle_op(input logic [63:0] a, input logic [63:0] b);
        @(negedge clk_i);
        in_valid_i = 1'b0; op_i = 4'h1; size_i = 2'b00; a_i = a; b_i = b;
        @(negedge clk_i);
        check("R1 idle valid", {63'h0, out_valid_o}, 64'h0);
        check("R1 idle hold", res_o, last_exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        logic [3:0]  rop;
        logic [1:0]  rsz;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        check("R10 reset valid", {63'h0, out_valid_o}, 64'h0);
        check("R10 reset res", res_o, 64'h0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);

        // R2: per-lane wrap, no carry between 16-bit lanes, but carry within 32-bit lanes
        run_op(4'h1, 2'b00, 64'h0001_FFFF_8000_FFFF, 64'h0001_0001_8000_0001);
        run_op(4'h1, 2'b01, 64'h0001_FFFF_8000_FFFF, 64'h0001_0001_8000_0001);
        // R3: b minus a, borrow stays in lane
        run_op(4'h2, 2'b00, 64'h0001_0001_0000_0001, 64'h0000_0005_0000_0000);
        run_op(4'h2, 2'b01, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0000);
        // R4: 32-bit data layouts clear the upper half
        run_op(4'h1, 2'b10, 64'hFFFF_FFFF_1234_FFFF, 64'h1111_1111_0001_0001);
        run_op(4'h2, 2'b11, 64'hAAAA_AAAA_0000_0001, 64'h5555_5555_0000_0000);
        // R5/R6/R7: unsigned compares, top-bit set lanes
        run_op(4'h4, 2'b00, 64'h8000_0001_0005_FFFF, 64'h7FFF_0001_0006_0000);
        run_op(4'h5, 2'b00, 64'h8000_0001_0005_FFFF, 64'h7FFF_0001_0006_FFFF);
        run_op(4'h6, 2'b01, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0001);
        run_op(4'h7, 2'b11, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0001);
        // R8: byte expand, b and size ignored
        run_op(4'h8, 2'b11, 64'hDEAD_BEEF_FF80_017F, 64'hFFFF_FFFF_FFFF_FFFF);
        // R9: illegal codes
        run_op(4'h0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op(4'h3, 2'b01, 64'h1234_5678_9ABC_DEF0, 64'h1);
        run_op(4'hF, 2'b10, 64'h1234_5678_9ABC_DEF0, 64'h1);
        // R1: hold while idle
        idle_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234);

        for (int i = 0; i < 600; i++) begin
            ra  = {$urandom, $urandom};
            rb  = {$urandom, $urandom};
            rop = 4'($urandom);
            rsz = 2'($urandom);
            if ($urandom % 3 == 0) rb = (ra & 64'hFFFF_0000_FFFF_0000) | (rb & 64'h0000_FFFF_0000_FFFF);
            if ($urandom % 4 == 0) rb = ra;
            run_op(rop, rsz, ra, rb);
            if ($urandom % 8 == 0) idle_op({$urandom, $urandom}, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule